// File: doc/BRIEF.md
# Seconds-of-day and day counter

This block keeps elapsed time from a slow, free-running 1 Hz square wave that arrives from outside the chip. The reference is brought into the system clock domain, and each of its rising edges becomes a one-cycle tick. Each tick advances a seconds-within-day count. When that count passes the last second of the day, it returns to midnight and issues a one-cycle day carry. The carry advances a count of whole days since a fixed epoch day (day 0).

The day count has a fixed capacity. When it rolls past its last value, it returns to zero and a sticky validity flag drops, because the date can no longer be trusted. Every day is the same length: no leap-year, leap-second or daylight-saving correction is made. A synchronous reset is the only way to restart time and to restore validity.

The outputs are plain status levels and one pulse. There is no load path and no back-pressure. The day length and the day capacity are parameters. The defaults are 86,400 seconds per day (a 17-bit count) and 8,192 days (a 13-bit count).

Top module: `elapsed_time_keeper`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after that edge, `sec_of_day_o` and `day_num_o` are 0, `day_carry_o` is 0 and `date_valid_o` is 1.
- R2: A rising edge of `ref_1hz_i` advances `sec_of_day_o` by exactly one. The new value appears on the third rising clock edge after the first edge that samples the input high. A level held high for any number of cycles gives only one step.
- R3: `sec_of_day_o` stays within 0 to SEC_PER_DAY-1. A tick at SEC_PER_DAY-1 returns it to 0.
- R4: `day_carry_o` is high for exactly one clock cycle, the cycle in which `sec_of_day_o` first shows 0 after a wrap. It is low at all other times.
- R5: `day_num_o` changes only in a cycle in which `day_carry_o` is high, and then it advances by one.
- R6: A carry while `day_num_o` is DAY_COUNT-1 returns `day_num_o` to 0.
- R7: `date_valid_o` falls in the same cycle that `day_num_o` wraps to 0. It then stays low until the next reset.
- R8: With no rising edge on `ref_1hz_i`, all outputs hold their values and `day_carry_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_1hz_i | input | 1 | External 1 Hz reference, asynchronous to clk |
| sec_of_day_o | output | $clog2(SEC_PER_DAY) | Seconds since midnight |
| day_num_o | output | $clog2(DAY_COUNT) | Whole days since the epoch day |
| day_carry_o | output | 1 | One-cycle pulse on each midnight wrap |
| date_valid_o | output | 1 | High until the day count has wrapped once |

## Verification
A midnight wrap of the seconds count and a roll-over of the day count can land on the same clock edge. On that edge the carry, the return of both counts to zero and the loss of validity must all appear together. The bench uses a short day and a small day capacity, so that it can run time past several midnights and through the final day. A behavioural model, built from the edge history of the reference, predicts every output, and the bench compares the model with the design on every clock. The same comparison covers a reset issued after validity has been lost, and reference pulses only one cycle wide that arrive back to back.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int unsigned SEC_PER_DAY_DEF = 86400;
  localparam int unsigned DAY_COUNT_DEF   = 8192;
  localparam int unsigned SYNC_DEPTH_DEF  = 2;
endpackage

// File: rtl/tk_edge_sync.sv
module tk_edge_sync #(
  parameter int unsigned DEPTH = tk_pkg::SYNC_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [DEPTH-1:0] chain_q;
  logic             last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[DEPTH-2:0], async_i};
      last_q  <= chain_q[DEPTH-1];
    end
  end

  assign rise_o = chain_q[DEPTH-1] & ~last_q;

  // R2: a tick never lasts two cycles
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tk_wrap_counter.sv
module tk_wrap_counter #(
  parameter int unsigned LIMIT = 10,
  localparam int unsigned W = $clog2(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (wrap_o)
      cnt_q <= '0;
    else if (step_i)
      cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  // R3: count stays within range
  p_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R2/R3: a change is either one step up or a return to zero after a wrap
  p_step_or_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_q) |-> ((cnt_q == $past(cnt_q) + 1'b1) ||
                         (cnt_q == '0 && $past(wrap_o))));
endmodule

// File: rtl/elapsed_time_keeper.sv
module elapsed_time_keeper #(
  parameter int unsigned SEC_PER_DAY = tk_pkg::SEC_PER_DAY_DEF,
  parameter int unsigned DAY_COUNT   = tk_pkg::DAY_COUNT_DEF,
  localparam int unsigned SEC_W = $clog2(SEC_PER_DAY),
  localparam int unsigned DAY_W = $clog2(DAY_COUNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_1hz_i,
  output logic [SEC_W-1:0] sec_of_day_o,
  output logic [DAY_W-1:0] day_num_o,
  output logic             day_carry_o,
  output logic             date_valid_o
);
  logic tick;
  logic midnight;
  logic day_roll;
  logic carry_q;
  logic valid_q;

  tk_edge_sync #(.DEPTH(tk_pkg::SYNC_DEPTH_DEF)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (ref_1hz_i),
    .rise_o  (tick)
  );

  tk_wrap_counter #(.LIMIT(SEC_PER_DAY)) u_sec (
    .clk     (clk),
    .rst     (rst),
    .step_i  (tick),
    .count_o (sec_of_day_o),
    .wrap_o  (midnight)
  );

  tk_wrap_counter #(.LIMIT(DAY_COUNT)) u_day (
    .clk     (clk),
    .rst     (rst),
    .step_i  (midnight),
    .count_o (day_num_o),
    .wrap_o  (day_roll)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      valid_q <= 1'b1;
    end else begin
      carry_q <= midnight;
      if (day_roll)
        valid_q <= 1'b0;
    end
  end

  assign day_carry_o  = carry_q;
  assign date_valid_o = valid_q;

  // R4: carry is one cycle wide
  p_carry_single_r4: assert property (@(posedge clk) disable iff (rst)
    day_carry_o |=> !day_carry_o);
  // R4: carry coincides with seconds at midnight
  p_carry_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
    day_carry_o |-> (sec_of_day_o == '0));
  // R5: day moves only with the carry
  p_day_with_carry_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(day_num_o) |-> day_carry_o);
  // R7: validity falls only on a day wrap
  p_valid_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(date_valid_o) |-> (day_carry_o && day_num_o == '0));
  // R7: validity is sticky
  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !date_valid_o |=> !date_valid_o);
endmodule

// File: tb/elapsed_time_keeper_tb.sv
module elapsed_time_keeper_tb;
  localparam int unsigned SPD  = 10;
  localparam int unsigned DAYS = 4;
  localparam int unsigned SW   = $clog2(SPD);
  localparam int unsigned DW   = $clog2(DAYS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_in = 1'b0;
  logic [SW-1:0] sec_o;
  logic [DW-1:0] day_o;
  logic          carry_o;
  logic          valid_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // reference model state
  int   m_sec = 0;
  int   m_day = 0;
  int   m_carry = 0;
  int   m_valid = 1;
  logic [3:0] hist = '0;

  always #4 clk = ~clk;

  elapsed_time_keeper #(.SEC_PER_DAY(SPD), .DAY_COUNT(DAYS)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .ref_1hz_i    (ref_in),
    .sec_of_day_o (sec_o),
    .day_num_o    (day_o),
    .day_carry_o  (carry_o),
    .date_valid_o (valid_o)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic compare_all(input string phase);
    check({phase, " R3 seconds"}, int'(sec_o), m_sec);
    check({phase, " R5/R6 day"}, int'(day_o), m_day);
    check({phase, " R4 carry"}, int'(carry_o), m_carry);
    check({phase, " R7 valid"}, int'(valid_o), m_valid);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic r, input logic rs, input string phase);
    bit tick;
    ref_in = r;
    rst = rs;
    @(posedge clk);
    if (rs) begin
      hist = '0; m_sec = 0; m_day = 0; m_carry = 0; m_valid = 1;
    end else begin
      hist = {hist[2:0], r};
      tick = hist[2] && !hist[3];
      m_carry = 0;
      if (tick) begin
        if (m_sec == SPD - 1) begin
          m_sec = 0;
          m_carry = 1;
          if (m_day == DAYS - 1) begin
            m_day = 0;
            m_valid = 0;
          end else begin
            m_day = m_day + 1;
          end
        end else begin
          m_sec = m_sec + 1;
        end
      end
    end
    @(negedge clk);
    compare_all(phase);
  endtask

  task automatic pulses(input int n, input int hi, input int lo, input string phase);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < hi; k++) step(1'b1, 1'b0, phase);
      for (int k = 0; k < lo; k++) step(1'b0, 1'b0, phase);
    end
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R1 reset");
    step(1'b0, 1'b0, "R1 after reset");
    pulses(25, 3, 3, "R2 steady seconds");
    pulses(1, 20, 5, "R2 long high level");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, "R8 idle");
    pulses(60, 3, 3, "R6 through day wrap");
    pulses(30, 1, 1, "R2 narrow pulses");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, "R1 reset again");
    step(1'b0, 1'b0, "R1 validity restored");
    pulses(12, 2, 4, "R3 after reset");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule